// File: doc/BRIEF.md
# Program Status Register Write Unit

This block keeps the processor's current status word and one saved status word per exception bank, and applies field-masked moves into either of them. A write carries a 32-bit operand, four lane enables and a select between the current word and the saved word of the running mode. Each lane enable covers one byte of the word: control, extension, status or flags. The current word drives the condition flags, the two interrupt-disable bits, the mode field, a privilege output and a one-cycle mode-change strobe.

Writes are filtered twice. In user mode only the flags byte of the current word may change. A saved-word write from a mode that owns no saved word is dropped without effect. A separate read port takes a mode number as its address and returns that mode's saved word one cycle later. It returns the current word when the mode owns no saved word. A configuration input selects the narrow 26-bit layout. In that layout every write to the current word keeps only the condition, interrupt and low mode bits.

Top module: `psr_update_unit`

## Requirements
- R1: A synchronous active-high reset sets the current word to 0x000000D3 (supervisor mode 0x13, I and F set), clears every saved word and the read data, drives `mode_changed` low and `privileged` high.
- R2: A current-word write (`wr_en`=1, `wr_saved`=0) replaces byte k (bits 8k+7..8k) with the operand's byte k when `wr_lanes[k]` is 1, keeps every other byte, and is visible on the outputs in the cycle after the write.
- R3: While the mode field is 0x10 or 0x00 (user), a current-word write applies only `wr_lanes[3]`; bytes 0 to 2 stay unchanged.
- R4: A saved-word write (`wr_en`=1, `wr_saved`=1) updates, byte by byte under `wr_lanes`, the saved word of the current mode's bank: fast interrupt (0x11, 0x01), interrupt (0x12, 0x02), supervisor (0x13, 0x03), abort (0x17) or undefined (0x1B). The current word stays unchanged.
- R5: A saved-word write in any other mode (user, system 0x1F or an unassigned code) changes no saved word and leaves the current word unchanged.
- R6: `rd_data` shows, one cycle after `rd_mode` is presented, the saved word of that mode's bank as it stood before that cycle's write. For a mode without a saved word it shows the current word as it stood before that cycle's write.
- R7: `mode_changed` is high for exactly the cycle in which a current-word write has just altered bits 4..0, with the new mode already on `cur_mode`.
- R8: `privileged` is high exactly when bits 1..0 of `cur_mode` are not both zero.
- R9: The flag outputs follow the current word: N bit 31, Z bit 30, C bit 29, V bit 28, interrupt mask bit 7, fast-interrupt mask bit 6, mode bits 4..0. `cpsr_out` shows the whole word.
- R10: With `cfg_narrow`=1, the current word after each write has every bit cleared except bits 31..28, 7..6 and 1..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_narrow | input | 1 | Selects the 26-bit status layout |
| wr_en | input | 1 | Write request |
| wr_saved | input | 1 | 1 targets the current mode's saved word, 0 the current word |
| wr_lanes | input | 4 | Byte enables: 0 control, 1 extension, 2 status, 3 flags |
| wr_data | input | 32 | Write operand |
| rd_mode | input | 5 | Mode whose saved word is read |
| rd_data | output | 32 | Registered read result |
| cpsr_out | output | 32 | Current status word |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| irq_mask | output | 1 | Interrupt disable |
| fiq_mask | output | 1 | Fast interrupt disable |
| cur_mode | output | 5 | Current mode field |
| privileged | output | 1 | Privileged access |
| mode_changed | output | 1 | One-cycle mode change strobe |

## Verification
A read and a write can land in the same cycle. Three collisions matter. A saved-word read can meet a write to that same saved word. A read of a bankless mode can meet a current-word write. A current-word write can meet a mode change, which moves the bank that later saved-word writes target. The bench provokes the first two with directed steps that read and write one bank in one cycle. It also runs random steps where `rd_mode` and the write target are drawn independently. Every read is judged against the model's value from before that cycle's update, so each collision must return the old word, and a mode switch must redirect only the following writes.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned LANE_W     = 8;
  localparam int unsigned LANES      = WORD_W / LANE_W;
  localparam int unsigned MODE_W     = 5;
  localparam int unsigned SAVED_CNT  = 5;
  localparam int unsigned SLOT_W     = $clog2(SAVED_CNT);

  localparam int unsigned POS_N   = 31;
  localparam int unsigned POS_Z   = 30;
  localparam int unsigned POS_C   = 29;
  localparam int unsigned POS_V   = 28;
  localparam int unsigned POS_I   = 7;
  localparam int unsigned POS_F   = 6;
  localparam int unsigned FLAG_LANE = 3;

  localparam logic [WORD_W-1:0] RESET_WORD  = 32'h0000_00D3;
  localparam logic [WORD_W-1:0] NARROW_KEEP = 32'hF000_00C3;

  typedef enum logic [2:0] {
    BK_USER, BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND, BK_SYS, BK_NONE
  } bank_e;
endpackage

// File: rtl/psr_bank_map.sv
module psr_bank_map
  import psr_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output bank_e             bank,
  output logic              has_saved,
  output logic [SLOT_W-1:0] slot,
  output logic              user_mode
);
  always_comb begin
    case (mode)
      5'h10, 5'h00: bank = BK_USER;
      5'h11, 5'h01: bank = BK_FIQ;
      5'h12, 5'h02: bank = BK_IRQ;
      5'h13, 5'h03: bank = BK_SVC;
      5'h17:        bank = BK_ABT;
      5'h1B:        bank = BK_UND;
      5'h1F:        bank = BK_SYS;
      default:      bank = BK_NONE;
    endcase
  end

  always_comb begin
    has_saved = 1'b1;
    slot      = '0;
    case (bank)
      BK_FIQ:  slot = SLOT_W'(0);
      BK_IRQ:  slot = SLOT_W'(1);
      BK_SVC:  slot = SLOT_W'(2);
      BK_ABT:  slot = SLOT_W'(3);
      BK_UND:  slot = SLOT_W'(4);
      default: has_saved = 1'b0;
    endcase
  end

  assign user_mode = (bank == BK_USER);
endmodule

// File: rtl/psr_lane_merge.sv
module psr_lane_merge #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned W     = LANES * LANE_W
) (
  input  logic [W-1:0]     old_word,
  input  logic [W-1:0]     new_word,
  input  logic [LANES-1:0] lanes,
  output logic [W-1:0]     merged
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign merged[k*LANE_W +: LANE_W] =
      lanes[k] ? new_word[k*LANE_W +: LANE_W] : old_word[k*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/psr_saved_store.sv
module psr_saved_store #(
  parameter int unsigned DEPTH  = 5,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned W     = LANES * LANE_W,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_slot,
  input  logic [LANES-1:0] wr_lanes,
  input  logic [W-1:0]     wr_word,
  input  logic             rd_hit,
  input  logic [IDX_W-1:0] rd_slot,
  input  logic [W-1:0]     rd_fallback,
  output logic [W-1:0]     rd_word
);
  logic [W-1:0] mem [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst)
          mem[e][k*LANE_W +: LANE_W] <= '0;
        else if (we && wr_lanes[k] && (wr_slot == IDX_W'(e)))
          mem[e][k*LANE_W +: LANE_W] <= wr_word[k*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_word <= '0;
    else if (rd_hit && (int'(rd_slot) < DEPTH))
      rd_word <= mem[rd_slot];
    else
      rd_word <= rd_fallback;
  end
endmodule

// File: rtl/psr_update_unit.sv
module psr_update_unit
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_narrow,
  input  logic              wr_en,
  input  logic              wr_saved,
  input  logic [LANES-1:0]  wr_lanes,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [MODE_W-1:0] rd_mode,
  output logic [WORD_W-1:0] rd_data,
  output logic [WORD_W-1:0] cpsr_out,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v,
  output logic              irq_mask,
  output logic              fiq_mask,
  output logic [MODE_W-1:0] cur_mode,
  output logic              privileged,
  output logic              mode_changed
);
  localparam logic [LANES-1:0] FLAGS_ONLY = LANES'(1) << FLAG_LANE;

  logic [WORD_W-1:0] cpsr_q;
  logic [WORD_W-1:0] cpsr_merged;
  logic [WORD_W-1:0] cpsr_next;
  logic [LANES-1:0]  cpsr_lanes;
  logic              cpsr_wr;
  logic              mc_q;
  logic              priv_q;

  bank_e             cur_bank;
  logic              cur_has;
  logic [SLOT_W-1:0] cur_slot;
  logic              cur_user;
  bank_e             rd_bank;
  logic              rd_has;
  logic [SLOT_W-1:0] rd_slot;
  logic              rd_user;

  psr_bank_map u_cur_map (
    .mode      (cpsr_q[MODE_W-1:0]),
    .bank      (cur_bank),
    .has_saved (cur_has),
    .slot      (cur_slot),
    .user_mode (cur_user)
  );

  psr_bank_map u_rd_map (
    .mode      (rd_mode),
    .bank      (rd_bank),
    .has_saved (rd_has),
    .slot      (rd_slot),
    .user_mode (rd_user)
  );

  assign cpsr_wr    = wr_en && !wr_saved;
  assign cpsr_lanes = !cpsr_wr ? '0 : (cur_user ? (wr_lanes & FLAGS_ONLY) : wr_lanes);

  psr_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
    .old_word (cpsr_q),
    .new_word (wr_data),
    .lanes    (cpsr_lanes),
    .merged   (cpsr_merged)
  );

  always_comb begin
    cpsr_next = cpsr_merged;
    if (cpsr_wr && cfg_narrow)
      cpsr_next = cpsr_merged & NARROW_KEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpsr_q <= RESET_WORD;
      mc_q   <= 1'b0;
      priv_q <= |RESET_WORD[1:0];
    end else begin
      cpsr_q <= cpsr_next;
      mc_q   <= cpsr_next[MODE_W-1:0] != cpsr_q[MODE_W-1:0];
      priv_q <= |cpsr_next[1:0];
    end
  end

  psr_saved_store #(.DEPTH(SAVED_CNT), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk         (clk),
    .rst         (rst),
    .we          (wr_en && wr_saved && cur_has),
    .wr_slot     (cur_slot),
    .wr_lanes    (wr_lanes),
    .wr_word     (wr_data),
    .rd_hit      (rd_has),
    .rd_slot     (rd_slot),
    .rd_fallback (cpsr_q),
    .rd_word     (rd_data)
  );

  assign cpsr_out     = cpsr_q;
  assign flag_n       = cpsr_q[POS_N];
  assign flag_z       = cpsr_q[POS_Z];
  assign flag_c       = cpsr_q[POS_C];
  assign flag_v       = cpsr_q[POS_V];
  assign irq_mask     = cpsr_q[POS_I];
  assign fiq_mask     = cpsr_q[POS_F];
  assign cur_mode     = cpsr_q[MODE_W-1:0];
  assign privileged   = priv_q;
  assign mode_changed = mc_q;

  logic unused_ok;
  assign unused_ok = rd_user ^ (rd_bank == BK_NONE) ^ (cur_bank == BK_NONE);
endmodule

// File: rtl/psr_update_unit_chk.sv
module psr_update_unit_chk
  import psr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cfg_narrow,
  input logic              wr_en,
  input logic              wr_saved,
  input logic [LANES-1:0]  wr_lanes,
  input logic [WORD_W-1:0] wr_data,
  input logic [MODE_W-1:0] rd_mode,
  input logic [WORD_W-1:0] rd_data,
  input logic [WORD_W-1:0] cpsr_out,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_c,
  input logic              flag_v,
  input logic              irq_mask,
  input logic              fiq_mask,
  input logic [MODE_W-1:0] cur_mode,
  input logic              privileged,
  input logic              mode_changed
);
  assert_reset_word_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cpsr_out == RESET_WORD) && !mode_changed);

  assert_user_lanes_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en && !wr_saved && !cfg_narrow && (cur_mode == 5'h10)))
      |-> cpsr_out[23:0] == $past(cpsr_out[23:0]));

  assert_saved_write_keeps_cpsr_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en && wr_saved)) |-> cpsr_out == $past(cpsr_out));

  assert_strobe_tracks_mode_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (mode_changed == (cur_mode != $past(cur_mode))));

  assert_priv_bits_R8: assert property (@(posedge clk) disable iff (rst)
    privileged == (cur_mode[1:0] != 2'b00));

  assert_narrow_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en && !wr_saved && cfg_narrow))
      |-> (cpsr_out & ~NARROW_KEEP) == '0);
endmodule

bind psr_update_unit psr_update_unit_chk u_chk (.*);

// File: tb/test_psr_update_unit.sv
module test_psr_update_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_narrow = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_saved = 1'b0;
  logic [3:0]  wr_lanes = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_mode = '0;
  logic [31:0] rd_data, cpsr_out;
  logic        flag_n, flag_z, flag_c, flag_v, irq_mask, fiq_mask;
  logic [4:0]  cur_mode;
  logic        privileged, mode_changed;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] cpsr_m;
  logic [31:0] spsr_m [5];

  always #5 clk = ~clk;

  psr_update_unit i_psr_update_unit (.*);

  function automatic int bank_idx(input logic [4:0] m);
    case (m)
      5'h11, 5'h01: return 0;
      5'h12, 5'h02: return 1;
      5'h13, 5'h03: return 2;
      5'h17:        return 3;
      5'h1B:        return 4;
      default:      return -1;
    endcase
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] ln);
    logic [31:0] r = o;
    for (int k = 0; k < 4; k++)
      if (ln[k]) r[k*8 +: 8] = n[k*8 +: 8];
    return r;
  endfunction

  function automatic logic [4:0] pick_mode(input int sel);
    case (sel % 12)
      0: return 5'h10;  1: return 5'h11;  2: return 5'h12;  3: return 5'h13;
      4: return 5'h17;  5: return 5'h1B;  6: return 5'h1F;  7: return 5'h00;
      8: return 5'h01;  9: return 5'h02; 10: return 5'h03;
      default: return 5'h14;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    wr_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    cpsr_m = 32'h0000_00D3;
    for (int i = 0; i < 5; i++) spsr_m[i] = '0;
    chk("R1 word", cpsr_out, 32'h0000_00D3);
    chk("R1 strobe", {31'd0, mode_changed}, 32'd0);
    chk("R1 priv", {31'd0, privileged}, 32'd1);
    chk("R1 rd", rd_data, 32'd0);
  endtask

  task automatic step(input bit en, input bit sel, input logic [3:0] ln,
                      input logic [31:0] d, input logic [4:0] rm, input bit nar);
    string tag;
    logic [31:0] exp_rd;
    logic [31:0] nw;
    logic [3:0]  eff;
    logic        exp_mc;
    int          ci;
    wr_en = en; wr_saved = sel; wr_lanes = ln; wr_data = d; rd_mode = rm; cfg_narrow = nar;
    exp_rd = (bank_idx(rm) >= 0) ? spsr_m[bank_idx(rm)] : cpsr_m;
    exp_mc = 1'b0;
    tag = "R2";
    if (en && !sel) begin
      eff = (cpsr_m[4:0] == 5'h10 || cpsr_m[4:0] == 5'h00) ? (ln & 4'b1000) : ln;
      if (eff != ln || cpsr_m[4:0] == 5'h10 || cpsr_m[4:0] == 5'h00) tag = "R3";
      nw = merge(cpsr_m, d, eff);
      if (nar) begin
        nw = nw & 32'hF000_00C3;
        tag = "R10";
      end
      exp_mc = nw[4:0] != cpsr_m[4:0];
      cpsr_m = nw;
    end else if (en && sel) begin
      ci = bank_idx(cpsr_m[4:0]);
      if (ci >= 0) begin
        spsr_m[ci] = merge(spsr_m[ci], d, ln);
        tag = "R4";
      end else begin
        tag = "R5";
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
    chk(tag, cpsr_out, cpsr_m);
    chk("R6", rd_data, exp_rd);
    chk("R7", {31'd0, mode_changed}, {31'd0, exp_mc});
    chk("R8", {31'd0, privileged}, {31'd0, cpsr_m[1:0] != 2'b00});
    chk("R9", {20'd0, flag_n, flag_z, flag_c, flag_v, irq_mask, fiq_mask, 1'b0, cur_mode},
        {20'd0, cpsr_m[31:28], cpsr_m[7:6], 1'b0, cpsr_m[4:0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    do_reset();

    // R7: control lane moves supervisor to fast interrupt mode
    step(1, 0, 4'b0001, 32'h0000_00D1, 5'h13, 0);
    // R4 with R6: same-cycle write and read of the fast interrupt saved word return old contents
    step(1, 1, 4'b1111, 32'hA5A5_5A31, 5'h11, 0);
    step(0, 0, 4'b0000, 32'h0, 5'h11, 0);
    // R6: bankless read returns current word, even with a same-cycle current write
    step(1, 0, 4'b1000, 32'h9000_0000, 5'h10, 0);
    // R5: system mode saved-word write is dropped
    step(1, 0, 4'b0001, 32'h0000_001F, 5'h1F, 0);
    step(1, 1, 4'b1111, 32'hDEAD_BEEF, 5'h11, 0);
    for (int m = 0; m < 12; m++) step(0, 0, 4'b0000, 32'h0, pick_mode(m), 0);
    // R3: user mode ignores lanes 0 to 2
    step(1, 0, 4'b0001, 32'h0000_0010, 5'h10, 0);
    step(1, 0, 4'b1111, 32'h5FFF_FF13, 5'h10, 0);
    // R10: narrow layout
    do_reset();
    step(1, 0, 4'b1111, 32'hFFFF_FFFF, 5'h03, 1);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      bit nar;
      if ((cpsr_m[4:0] == 5'h10 || cpsr_m[4:0] == 5'h00) && ($urandom % 6 == 0)) begin
        do_reset();
      end
      d = $urandom;
      d[4:0] = pick_mode($urandom % 12);
      nar = (i >= 2200);
      step(($urandom % 5) != 0, $urandom % 2, 4'($urandom), d, pick_mode($urandom % 12), nar);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule